// File: doc/BRIEF.md
# Lane-Split Multi-Read-Address RAM

This block is a small 32-entry memory whose 8-bit word is split into four 2-bit lanes. A single clocked write port stores a whole word at one location. The location is given by the fourth address, and each lane takes its bits from its own 2-bit data input. Every lane also has a combinational read port with its own 5-bit address. This lets the four lanes of the stored words be observed at four different locations in the same cycle.

The fourth lane uses its address for both the write and the read. The other three lanes only read at their addresses. Tying pins together at the instance gives other memories. The same data on every lane input gives a 32x2 memory with one read/write port and three read ports. Tying the first three addresses together and leaving the fourth lane unused gives a 32x6 simple dual-port memory. Tying all four addresses together gives a 32x8 single-port memory. Contents start at zero and are never reset.

Top module: `lane_split_ram`

## Requirements
- R1: The memory has 32 entries addressed by 5-bit buses. Each of the four lanes returns data from its own address, independently of the addresses of the other lanes.
- R2: A write takes place only on a rising clock edge with `wr_en` high. While `wr_en` is low, no entry changes, whatever the data inputs carry.
- R3: A write stores `din_a`, `din_b`, `din_c` and `din_d` together into the entry selected by `addr_d`. Exactly one entry is written per enabled edge.
- R4: `dout_a`, `dout_b` and `dout_c` return the bits last written through `din_a`, `din_b` and `din_c`, read at `addr_a`, `addr_b` and `addr_c` respectively.
- R5: `dout_d` returns the bits last written through `din_d` at `addr_d`, so one address serves both the write and the read of that lane.
- R6: Reads are combinational. Changing an address changes the output without a clock edge. A read of the entry being written shows the old value before the write edge and the new value after it.
- R7: All entries read as zero from the start of operation, without any reset.
- R8: With the same 2-bit value on all four data inputs, the block behaves as a 32x2 memory with one read/write port (`addr_d`) and three independent read ports.
- R9: With `addr_a`, `addr_b` and `addr_c` tied together and lane D unused, the block behaves as a 32x6 simple dual-port memory: 6-bit writes at `addr_d` and 6-bit reads at the shared address.
- R10: With all four addresses tied together, the block behaves as a 32x8 single-port memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock, rising edge |
| wr_en | input | 1 | Write enable for the whole word |
| din_a | input | 2 | Write data for lane A |
| din_b | input | 2 | Write data for lane B |
| din_c | input | 2 | Write data for lane C |
| din_d | input | 2 | Write data for lane D |
| addr_a | input | 5 | Read address of lane A |
| addr_b | input | 5 | Read address of lane B |
| addr_c | input | 5 | Read address of lane C |
| addr_d | input | 5 | Write address of all lanes and read address of lane D |
| dout_a | output | 2 | Lane A read data |
| dout_b | output | 2 | Lane B read data |
| dout_c | output | 2 | Lane C read data |
| dout_d | output | 2 | Lane D read data |

## Verification
The following properties are checked on every cycle:
- The entry strobe is one-hot exactly when a write is enabled.
- A lane whose read address matches the previous write address shows the written bits one edge later.
- With the enable low and the addresses held, every output stays unchanged.

Only the bench scenarios can show:
- The zero start state.
- Correct data at unrelated, independently chosen addresses.
- The combinational read before the write edge.
- The tied-pin quad-port, simple dual-port and single-port uses.

The bench checks all of these against a full 32x8 reference array.

// File: rtl/lane_ram_pkg.sv
package lane_ram_pkg;

    localparam int unsigned LANES_DEF  = 4;
    localparam int unsigned LANE_W_DEF = 2;
    localparam int unsigned DEPTH_DEF  = 32;
    localparam int unsigned ADDR_W_DEF = $clog2(DEPTH_DEF);
    localparam int unsigned WORD_W_DEF = LANES_DEF * LANE_W_DEF;

    // Lane order matters: the last lane shares its address with the write port.
    typedef enum logic [1:0] {
        LANE_A = 2'd0,
        LANE_B = 2'd1,
        LANE_C = 2'd2,
        LANE_D = 2'd3
    } lane_id_e;

    localparam lane_id_e WR_ADDR_LANE = LANE_D;

    typedef logic [LANE_W_DEF-1:0] lane_t;
    typedef logic [ADDR_W_DEF-1:0] addr_t;

    typedef struct packed {
        logic  en;
        addr_t addr;
    } wr_ctl_t;

    // Bit offset of a lane inside the full word.
    function automatic int unsigned lane_lsb(input lane_id_e id);
        return int'(id) * LANE_W_DEF;
    endfunction

endpackage

// File: rtl/lane_wr_dec.sv
module lane_wr_dec #(
    parameter int unsigned DEPTH  = lane_ram_pkg::DEPTH_DEF,
    parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic [DEPTH-1:0]  stb
);

    always_comb begin
        stb = '0;
        if (en && (int'(addr) < int'(DEPTH))) begin
            stb[addr] = 1'b1;
        end
    end

endmodule

// File: rtl/lane_rd_mux.sv
module lane_rd_mux #(
    parameter int unsigned DEPTH  = lane_ram_pkg::DEPTH_DEF,
    parameter int unsigned W      = lane_ram_pkg::LANE_W_DEF,
    parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic [DEPTH*W-1:0] cells,
    input  logic [ADDR_W-1:0]  raddr,
    output logic [W-1:0]       dout
);

    always_comb begin
        dout = '0;
        for (int e = 0; e < int'(DEPTH); e++) begin
            if (int'(raddr) == e) begin
                dout = cells[e*W +: W];
            end
        end
    end

endmodule

// File: rtl/lane_bank.sv
module lane_bank #(
    parameter int unsigned DEPTH  = lane_ram_pkg::DEPTH_DEF,
    parameter int unsigned W      = lane_ram_pkg::LANE_W_DEF,
    parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [DEPTH-1:0]  stb,
    input  logic [W-1:0]      din,
    input  logic [ADDR_W-1:0] raddr,
    output logic [W-1:0]      dout
);

    logic [DEPTH*W-1:0] cells_flat;

    // One register per entry; contents start at zero and have no reset.
    for (genvar e = 0; e < int'(DEPTH); e++) begin : g_entry
        logic [W-1:0] cell_q = '0;
        always_ff @(posedge clk) begin
            if (stb[e]) begin
                cell_q <= din;
            end
        end
        assign cells_flat[e*W +: W] = cell_q;
    end

    lane_rd_mux #(
        .DEPTH (DEPTH),
        .W     (W),
        .ADDR_W(ADDR_W)
    ) u_mux (
        .cells(cells_flat),
        .raddr(raddr),
        .dout (dout)
    );

endmodule

// File: rtl/lane_split_ram.sv
module lane_split_ram
    import lane_ram_pkg::*;
#(
    parameter int unsigned DEPTH  = DEPTH_DEF,
    parameter int unsigned LANE_W = LANE_W_DEF,
    localparam int unsigned ADDR_W = $clog2(DEPTH),
    localparam int unsigned NLANE  = LANES_DEF
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [LANE_W-1:0] din_a,
    input  logic [LANE_W-1:0] din_b,
    input  logic [LANE_W-1:0] din_c,
    input  logic [LANE_W-1:0] din_d,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [ADDR_W-1:0] addr_c,
    input  logic [ADDR_W-1:0] addr_d,
    output logic [LANE_W-1:0] dout_a,
    output logic [LANE_W-1:0] dout_b,
    output logic [LANE_W-1:0] dout_c,
    output logic [LANE_W-1:0] dout_d
);

    logic [LANE_W-1:0] din_v  [NLANE];
    logic [ADDR_W-1:0] raddr_v[NLANE];
    logic [LANE_W-1:0] dout_v [NLANE];
    logic [DEPTH-1:0]  wr_stb;
    logic              wr_ctl_en;
    logic [ADDR_W-1:0] wr_ctl_addr;

    assign din_v[LANE_A] = din_a;
    assign din_v[LANE_B] = din_b;
    assign din_v[LANE_C] = din_c;
    assign din_v[LANE_D] = din_d;

    assign raddr_v[LANE_A] = addr_a;
    assign raddr_v[LANE_B] = addr_b;
    assign raddr_v[LANE_C] = addr_c;
    assign raddr_v[LANE_D] = addr_d;

    // The shared write address is the read address of the last lane.
    assign wr_ctl_en   = wr_en;
    assign wr_ctl_addr = raddr_v[WR_ADDR_LANE];

    lane_wr_dec #(
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W)
    ) u_dec (
        .en  (wr_ctl_en),
        .addr(wr_ctl_addr),
        .stb (wr_stb)
    );

    for (genvar l = 0; l < int'(NLANE); l++) begin : g_lane
        lane_bank #(
            .DEPTH (DEPTH),
            .W     (LANE_W),
            .ADDR_W(ADDR_W)
        ) u_bank (
            .clk  (clk),
            .stb  (wr_stb),
            .din  (din_v[l]),
            .raddr(raddr_v[l]),
            .dout (dout_v[l])
        );
    end

    assign dout_a = dout_v[LANE_A];
    assign dout_b = dout_v[LANE_B];
    assign dout_c = dout_v[LANE_C];
    assign dout_d = dout_v[LANE_D];

endmodule

// File: rtl/lane_split_ram_chk.sv
module lane_split_ram_chk #(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned LANE_W = 2,
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              wr_en,
    input logic [LANE_W-1:0] din_a,
    input logic [LANE_W-1:0] din_b,
    input logic [LANE_W-1:0] din_c,
    input logic [LANE_W-1:0] din_d,
    input logic [ADDR_W-1:0] addr_a,
    input logic [ADDR_W-1:0] addr_b,
    input logic [ADDR_W-1:0] addr_c,
    input logic [ADDR_W-1:0] addr_d,
    input logic [LANE_W-1:0] dout_a,
    input logic [LANE_W-1:0] dout_b,
    input logic [LANE_W-1:0] dout_c,
    input logic [LANE_W-1:0] dout_d,
    input logic [DEPTH-1:0]  wr_stb
);

    // Stays low until the first edge has been seen, so $past never looks before start.
    logic warm_q = 1'b0;
    always_ff @(posedge clk) warm_q <= 1'b1;

    p_idle_no_strobe_r2: assert property (@(posedge clk) disable iff (!warm_q)
        !wr_en |-> (wr_stb == '0));

    p_one_entry_r3: assert property (@(posedge clk) disable iff (!warm_q)
        wr_en |-> ($countones(wr_stb) == 1 && wr_stb[addr_d]));

    p_hold_a_r2: assert property (@(posedge clk) disable iff (!warm_q)
        !wr_en |=> ($stable(addr_a) -> $stable(dout_a)));
    p_hold_b_r2: assert property (@(posedge clk) disable iff (!warm_q)
        !wr_en |=> ($stable(addr_b) -> $stable(dout_b)));
    p_hold_c_r2: assert property (@(posedge clk) disable iff (!warm_q)
        !wr_en |=> ($stable(addr_c) -> $stable(dout_c)));
    p_hold_d_r2: assert property (@(posedge clk) disable iff (!warm_q)
        !wr_en |=> ($stable(addr_d) -> $stable(dout_d)));

    p_wr_lane_a_r4: assert property (@(posedge clk) disable iff (!warm_q)
        wr_en |=> ((addr_a == $past(addr_d)) -> (dout_a == $past(din_a))));
    p_wr_lane_b_r4: assert property (@(posedge clk) disable iff (!warm_q)
        wr_en |=> ((addr_b == $past(addr_d)) -> (dout_b == $past(din_b))));
    p_wr_lane_c_r4: assert property (@(posedge clk) disable iff (!warm_q)
        wr_en |=> ((addr_c == $past(addr_d)) -> (dout_c == $past(din_c))));
    p_wr_lane_d_r5: assert property (@(posedge clk) disable iff (!warm_q)
        wr_en |=> ($stable(addr_d) -> (dout_d == $past(din_d))));

endmodule

bind lane_split_ram lane_split_ram_chk #(
    .DEPTH (DEPTH),
    .LANE_W(LANE_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk   (clk),
    .wr_en (wr_en),
    .din_a (din_a),
    .din_b (din_b),
    .din_c (din_c),
    .din_d (din_d),
    .addr_a(addr_a),
    .addr_b(addr_b),
    .addr_c(addr_c),
    .addr_d(addr_d),
    .dout_a(dout_a),
    .dout_b(dout_b),
    .dout_c(dout_c),
    .dout_d(dout_d),
    .wr_stb(wr_stb)
);

// File: tb/tb_lane_split_ram.sv
module tb_lane_split_ram;

    typedef struct {
        logic [7:0]  exp;
        logic [19:0] addrs;
        string       tag;
    } item_t;

    logic       clk = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] din_a = '0, din_b = '0, din_c = '0, din_d = '0;
    logic [4:0] addr_a = '0, addr_b = '0, addr_c = '0, addr_d = '0;
    logic [1:0] dout_a, dout_b, dout_c, dout_d;

    logic [7:0] ref_mem [32];
    item_t      sb_q[$];
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #2ns clk = ~clk;

    lane_split_ram dut (
        .clk(clk), .wr_en(wr_en),
        .din_a(din_a), .din_b(din_b), .din_c(din_c), .din_d(din_d),
        .addr_a(addr_a), .addr_b(addr_b), .addr_c(addr_c), .addr_d(addr_d),
        .dout_a(dout_a), .dout_b(dout_b), .dout_c(dout_c), .dout_d(dout_d)
    );

    // Driver: applies one cycle of stimulus, predicts the read-out, updates the model.
    task automatic step(input bit we,
                        input logic [1:0] da, input logic [1:0] db,
                        input logic [1:0] dc, input logic [1:0] dd,
                        input logic [4:0] aa, input logic [4:0] ab,
                        input logic [4:0] ac, input logic [4:0] ad,
                        input string tag);
        item_t it;
        @(negedge clk);
        wr_en = we;
        din_a = da; din_b = db; din_c = dc; din_d = dd;
        addr_a = aa; addr_b = ab; addr_c = ac; addr_d = ad;
        #1ns;
        it.exp   = {ref_mem[ad][7:6], ref_mem[ac][5:4], ref_mem[ab][3:2], ref_mem[aa][1:0]};
        it.addrs = {aa, ab, ac, ad};
        it.tag   = tag;
        sb_q.push_back(it);
        if (we) ref_mem[ad] = {dd, dc, db, da};
    endtask

    // Monitor: pops each prediction and compares it with the four read ports.
    initial begin : monitor
        item_t      it;
        logic [7:0] act;
        forever begin
            wait (sb_q.size() != 0);
            it  = sb_q.pop_front();
            act = {dout_d, dout_c, dout_b, dout_a};
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s addr(a,b,c,d)=%h actual=%h expected=%h",
                         it.tag, it.addrs, act, it.exp);
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stimulus
        logic [4:0] x;
        logic [4:0] y;
        logic [1:0] v;
        void'($urandom(7));
        for (int i = 0; i < 32; i++) ref_mem[i] = 8'h00;

        // R7: zero start state; writes disabled while data toggles
        for (int i = 0; i < 32; i++)
            step(1'b0, 2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
                 5'(i), 5'(i + 7), 5'(i + 13), 5'(i + 21), "R7");

        // R3: fill every entry through the shared write address
        for (int i = 0; i < 32; i++)
            step(1'b1, 2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
                 5'($urandom), 5'($urandom), 5'($urandom), 5'(i), "R3");

        // R2: disabled cycles with busy data must leave all entries alone
        for (int i = 0; i < 64; i++)
            step(1'b0, 2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
                 5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom), "R2");
        for (int i = 0; i < 32; i++)
            step(1'b0, 2'b11, 2'b11, 2'b11, 2'b11,
                 5'(i), 5'(31 - i), 5'(i + 16), 5'(i + 3), "R2");

        // R1 / R4 / R5: independent random addresses with mixed writes
        for (int i = 0; i < 400; i++)
            step(1'($urandom), 2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
                 5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom),
                 (i % 3 == 0) ? "R1" : ((i % 3 == 1) ? "R4" : "R5"));

        // R6: old data before the write edge, new data right after
        for (int i = 0; i < 8; i++) begin
            x = 5'($urandom);
            step(1'b1, 2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
                 x, x, x, x, "R6");
            step(1'b0, 2'b00, 2'b00, 2'b00, 2'b00, x, x, x, x, "R6");
            step(1'b0, 2'b00, 2'b00, 2'b00, 2'b00, x + 5'd1, x, x + 5'd2, x, "R6");
        end

        // R8: same data on every lane: 1 read/write + 3 read ports of 32x2
        for (int i = 0; i < 100; i++) begin
            v = 2'($urandom);
            step(1'($urandom), v, v, v, v,
                 5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom), "R8");
        end

        // R9: tied read address for lanes A..C, lane D grounded
        for (int i = 0; i < 100; i++) begin
            x = 5'($urandom);
            y = 5'($urandom);
            step(1'($urandom), 2'($urandom), 2'($urandom), 2'($urandom), 2'b00,
                 x, x, x, y, "R9");
        end

        // R10: all addresses tied: single-port 32x8
        for (int i = 0; i < 100; i++) begin
            x = 5'($urandom % 8);
            step(1'($urandom), 2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
                 x, x, x, x, "R10");
        end

        @(negedge clk);
        wait (sb_q.size() == 0);
        #1ns;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule